// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen asynchronous input lines and turns selected transitions on them into interrupts. Every line has its own rising-edge select and falling-edge select, so it can fire on either edge or on both. When a selected transition is seen on a line that software has enabled, the block sets that line's sticky pending bit and raises that line's interrupt output for exactly one clock cycle.

Software programs the block through a small 32-bit register bus with separate read and write strobes, decoded over a 1 KiB window. Besides the enable, rising and falling selects and the pending register, the block holds an event-mask register and a software-event register. Both are plain storage here; nothing in the block reads them. Pending bits stay set until software writes a 1 to them.

Top module: `eirq_ctrl`

## Requirements
- R1: The block has LINES (default 16) input lines `lines_in` and the same number of interrupt outputs `irq_out`. Bit i of the output belongs only to bit i of the input.
- R2: The registers sit at these byte offsets: enable mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software event 0x10 and pending 0x14. Bit i of each register belongs to line i. `bus_rdata` is registered: it shows the addressed register in the cycle after the clock edge that samples `bus_rd`.
- R3: After reset, all six registers read zero and `irq_out` is zero.
- R4: A line whose enable bit is 0 is ignored. Its edges give no output pulse and do not set its pending bit.
- R5: On an enabled line whose rising-select bit is 1, a 0-to-1 transition produces a one-cycle pulse on that line's output and sets its pending bit.
- R6: On an enabled line whose falling-select bit is 1, a 1-to-0 transition produces a one-cycle pulse on that line's output and sets its pending bit. If both selects are set, every transition fires.
- R7: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. Pending bits above LINES-1 read zero.
- R8: If a selected edge and a clearing write reach the same pending bit on the same clock edge, the bit ends up set.
- R9: A read from an offset that is not one of the six words returns zero. A write to such an offset changes nothing. Offsets that are not word-aligned count as undefined.
- R10: The enable, event-mask, select and software-event registers store all 32 written bits and read them back. The event-mask and software-event registers have no effect on `irq_out` or on the pending bits.
- R11: Each input passes through a two-flop synchronizer before edge detection. A transition's pulse and pending bit appear on the third rising clock edge, counting the edge that first samples the new level. The pulse is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 10 | Byte address within the 1 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lines_in | input | 16 | Asynchronous external lines |
| irq_out | output | 16 | One-cycle interrupt pulses, one per line |

## Verification
Directed patterns drive single rising and single falling transitions under each select. These tell apart the two trigger polarities and show that a disabled line is ignored. A random run changes many lines at once while the enable and select settings vary, which checks that lines stay independent and that the edge model matches. Further cases line up a clearing write with a new edge on the same clock, and write to undefined and unaligned offsets. The first separates "event wins" from "clear wins". The second shows that such writes leave every register unchanged.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned NUM_CFG = 5;
  localparam logic [7:0] WI_MASK  = 8'd0;
  localparam logic [7:0] WI_EVM   = 8'd1;
  localparam logic [7:0] WI_RISE  = 8'd2;
  localparam logic [7:0] WI_FALL  = 8'd3;
  localparam logic [7:0] WI_SWEV  = 8'd4;
  localparam logic [7:0] WI_PEND  = 8'd5;
endpackage

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lines_in,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], lines_in[i]};
        prev_q <= sync_q[STAGES-1];
      end
    end
    assign rise[i] = sync_q[STAGES-1] & ~prev_q;
    assign fall[i] = ~sync_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic [LINES-1:0]  pend_q,
  output logic [LINES-1:0]  mask_q,
  output logic [LINES-1:0]  rise_sel,
  output logic [LINES-1:0]  fall_sel,
  output logic [LINES-1:0]  clr_mask,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic             aligned;
  logic [BUS_W-1:0] cfg_q [NUM_CFG];
  logic [BUS_W-1:0] rd_mux;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[r] <= '0;
      end else if (bus_wr && aligned && (widx == IDX_W'(r))) begin
        cfg_q[r] <= bus_wdata;
      end
    end
  end

  assign mask_q   = cfg_q[WI_MASK][LINES-1:0];
  assign rise_sel = cfg_q[WI_RISE][LINES-1:0];
  assign fall_sel = cfg_q[WI_FALL][LINES-1:0];
  assign clr_mask = (bus_wr && aligned && (widx == IDX_W'(WI_PEND)))
                    ? bus_wdata[LINES-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx < IDX_W'(NUM_CFG)) begin
        rd_mux = cfg_q[widx[2:0]];
      end else if (widx == IDX_W'(WI_PEND)) begin
        rd_mux = BUS_W'(pend_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/eirq_pend.sv
module eirq_pend #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] fall,
  input  logic [LINES-1:0] mask_q,
  input  logic [LINES-1:0] rise_sel,
  input  logic [LINES-1:0] fall_sel,
  input  logic [LINES-1:0] clr_mask,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] irq_out
);
  logic [LINES-1:0] hit;

  assign hit = mask_q & ((rise & rise_sel) | (fall & fall_sel));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      irq_out <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr_mask) | hit;
      irq_out <= hit;
    end
  end
endmodule

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
#(
  parameter int unsigned LINES  = 16,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [LINES-1:0]  lines_in,
  output logic [LINES-1:0]  irq_out
);
  logic [LINES-1:0] rise, fall, mask_q, rise_sel, fall_sel, clr_mask, pend_q;

  eirq_edge #(.LINES(LINES), .STAGES(STAGES)) edge_i (
    .clk(clk), .rst(rst), .lines_in(lines_in), .rise(rise), .fall(fall)
  );

  eirq_regs #(.LINES(LINES), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
    .mask_q(mask_q), .rise_sel(rise_sel), .fall_sel(fall_sel),
    .clr_mask(clr_mask), .bus_rdata(bus_rdata)
  );

  eirq_pend #(.LINES(LINES)) pend_i (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .mask_q(mask_q),
    .rise_sel(rise_sel), .fall_sel(fall_sel), .clr_mask(clr_mask),
    .pend_q(pend_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/eirq_ctrl_chk.sv
module eirq_ctrl_chk #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic [LINES-1:0]  irq_out,
  input logic [LINES-1:0]  mask_q,
  input logic [LINES-1:0]  pend_q,
  input logic [LINES-1:0]  clr_mask
);
  p_reset_clear_r3: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && irq_out == '0 && mask_q == '0));

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~$past(mask_q)) == '0);

  p_pulse_sets_pend_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_out & ~pend_q) == '0);

  p_clear_only_w1_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(pend_q) & ~pend_q & ~$past(clr_mask)) == '0);

  p_event_wins_r8: assert property (@(posedge clk) disable iff (rst)
    $past(clr_mask != '0) |-> (irq_out & ~pend_q) == '0);

  p_undef_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr[1:0] != 2'b00 || bus_addr[ADDR_W-1:2] > 5))
    |=> bus_rdata == 32'd0);
endmodule

bind eirq_ctrl eirq_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .mask_q(mask_q), .pend_q(pend_q), .clr_mask(clr_mask)
);

// File: tb/eirq_ctrl_tb_top.sv
module eirq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] lines_in = '0;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_mask = 0, m_evm = 0, m_rise = 0, m_fall = 0, m_swev = 0;
  logic [15:0] m_pend = 0, m_cur = 0;

  always #10 clk = ~clk;

  eirq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lines_in(lines_in), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] edge_hits(input logic [15:0] oldv,
                                            input logic [15:0] newv);
    return m_mask[15:0] & ((m_rise[15:0] & newv & ~oldv) |
                           (m_fall[15:0] & ~newv & oldv));
  endfunction

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      10'h000: m_mask = d;
      10'h004: m_evm  = d;
      10'h008: m_rise = d;
      10'h00C: m_fall = d;
      10'h010: m_swev = d;
      10'h014: m_pend = m_pend & ~d[15:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp,
                        input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic drive(input logic [15:0] v, input string req);
    logic [15:0] exp;
    exp = edge_hits(m_cur, v);
    @(negedge clk);
    lines_in = v;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 3) chk(irq_out == exp, req, irq_out, exp);
      else        chk(irq_out == 16'h0, {req, " R11 latency"}, irq_out, 0);
    end
    m_pend = m_pend | exp;
    m_cur = v;
  endtask

  task automatic all_regs(input string req);
    rd_chk(10'h000, m_mask, req);
    rd_chk(10'h004, m_evm, req);
    rd_chk(10'h008, m_rise, req);
    rd_chk(10'h00C, m_fall, req);
    rd_chk(10'h010, m_swev, req);
    rd_chk(10'h014, {16'h0, m_pend}, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic [31:0] d;
    seed = 32'd1234;
    d = $urandom(seed);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk(irq_out == 16'h0, "R3 irq reset", irq_out, 0);
    all_regs("R3 reset values");

    // masked line: no pulse, no pending
    wr(10'h008, 32'hFFFF);
    wr(10'h00C, 32'hFFFF);
    drive(16'h00FF, "R4 masked rise");
    drive(16'h0000, "R4 masked fall");
    rd_chk(10'h014, 0, "R4 masked pending");

    // rising only on line 3
    wr(10'h000, 32'h0000_0008);
    wr(10'h00C, 32'h0);
    wr(10'h008, 32'h0000_0008);
    drive(16'h0008, "R5 rise line3");
    drive(16'h0000, "R5 fall ignored");
    rd_chk(10'h014, 32'h8, "R5 pending");

    // falling only on line 12
    wr(10'h000, 32'h0000_1000);
    wr(10'h008, 32'h0);
    wr(10'h00C, 32'h0000_1000);
    drive(16'h1000, "R6 rise ignored");
    drive(16'h0000, "R6 fall line12");
    wr(10'h008, 32'h0000_1000);
    drive(16'h1000, "R6 both rise");
    drive(16'h0000, "R6 both fall");
    rd_chk(10'h014, 32'h1008, "R6 pending");

    // write-1-to-clear
    wr(10'h014, 32'hFFFF_0008);
    rd_chk(10'h014, 32'h1000, "R7 partial clear");

    // event and clear on same edge
    wr(10'h000, 32'h0000_0003);
    wr(10'h008, 32'h0000_0003);
    wr(10'h00C, 32'h0);
    drive(16'h0002, "R8 setup line1");
    @(negedge clk);
    lines_in = 16'h0003;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 10'h014; bus_wdata = 32'hFFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(irq_out == 16'h0001, "R8 pulse", irq_out, 1);
    m_pend = 16'h0001;
    m_cur = 16'h0003;
    rd_chk(10'h014, 32'h1, "R8 event wins over clear");

    // undefined offsets
    wr(10'h018, 32'hFFFF_FFFF);
    wr(10'h3FC, 32'hFFFF_FFFF);
    wr(10'h001, 32'hFFFF_FFFF);
    all_regs("R9 undefined write no effect");
    rd_chk(10'h018, 0, "R9 read 0x18");
    rd_chk(10'h3FC, 0, "R9 read 0x3FC");
    rd_chk(10'h001, 0, "R9 read unaligned");

    // plain storage and no effect of event mask / sw event
    wr(10'h004, 32'hA5A5_5A5A);
    wr(10'h010, 32'h1234_FFFF);
    wr(10'h000, 32'hDEAD_0000);
    drive(16'h0000, "R10 evm no effect");
    all_regs("R10 readback");

    // random mix
    for (int it = 0; it < 80; it++) begin
      if (it % 4 == 0) begin
        wr(10'h000, $urandom);
        wr(10'h008, $urandom);
        wr(10'h00C, $urandom);
        wr(10'h004, $urandom);
        wr(10'h010, $urandom);
      end
      drive(16'($urandom), "R1 R5 R6 random");
      if (it % 5 == 4) begin
        rd_chk(10'h014, {16'h0, m_pend}, "R1 R7 random pending");
        wr(10'h014, $urandom);
      end
    end
    all_regs("R2 final readback");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule